// File: doc/BRIEF.md
# I2C Slave Register-Access Engine

This block is the serial front end of an 8-bit port expander. It oversamples the I2C clock and data lines with a system clock, cleans them through a synchronizer and a majority vote, and turns their transitions into bus events: start, repeated start, stop, clock rise and clock fall. It answers one 7-bit address. The upper four bits of that address are fixed at 0b0011 and the lower three come from strap inputs, so the address lies somewhere in 0x18 to 0x1F.

In a write transaction the first byte after the address is a command byte. Its two low bits choose one of four registers, and the choice is held in a register pointer. Every following byte is handed to the register bank as a one-cycle write strobe with its data. In a read transaction the engine shifts out the byte that the bank presents for the current pointer. It signals each fetch with a one-cycle read request.

The pointer never advances on its own. It also survives a repeated start, so a write of a command byte followed by a restart and a read returns the chosen register. The SDA output is an open-drain pull-down enable.

Top module: `i2c_regacc_engine`

## Requirements
- R1: The engine acknowledges an address byte whose upper seven bits equal {0,0,1,1,strap[2],strap[1],strap[0]}. It does this by pulling SDA low through the high phase of the ninth clock. Bit 0 of the address byte selects the direction: 1 means read and 0 means write.
- R2: After an address that does not match, the engine stays silent until the next start or stop. It gives no acknowledge, no write strobe and no read request, the pointer keeps its value, and a master reading the bus sees only 0xFF.
- R3: The pull-down enable changes only while SCL is low. A value of 1 on the enable means SDA is driven low.
- R4: In a write, every data byte after the command byte is received MSB first and acknowledged. Each one produces exactly one write-strobe pulse with that byte on the write-data output.
- R5: The first byte after a matched write address is the command byte. It is acknowledged, and its bits [1:0] become the pointer (00 input, 01 output, 10 polarity, 11 direction). Its bits [7:2] are ignored.
- R6: The pointer never auto-increments. All data bytes of one write are strobed while the same pointer value is held.
- R7: The pointer is kept across a repeated start. A read that follows returns the register selected before the restart, byte after byte.
- R8: In a read, each byte is taken from the read-data input and sent MSB first, and every byte loaded raises one read-request pulse. A master ACK continues the read. A master NACK makes the engine release SDA and drive nothing more until the next start or stop.
- R9: Reset returns the engine to idle: SDA released, pointer 00, no strobes. A read with no earlier command byte therefore returns register 00.
- R10: A disturbance of one system-clock cycle on SCL or SDA has no effect. This holds even when the disturbance, if it were taken at face value, would form an extra clock edge, a false start or a false stop.
- R11: After a stop, clocked bytes that are not preceded by a start get no acknowledge and cause no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw I2C clock line level |
| sda_i | input | 1 | Raw I2C data line level |
| strap_i | input | 3 | Strap bits forming the low three address bits |
| rd_data_i | input | 8 | Current value of the register selected by reg_sel_o |
| sda_pull_o | output | 1 | Open-drain enable; 1 pulls SDA low |
| reg_sel_o | output | 2 | Register pointer loaded from the command byte |
| wr_data_o | output | 8 | Last received data byte |
| wr_stb_o | output | 1 | One-cycle pulse: write wr_data_o to register reg_sel_o |
| rd_req_o | output | 1 | One-cycle pulse: rd_data_i has been taken for transmission |

## Verification
Several rules are checked by assertions on every cycle:
- the pull-down enable changes only while the filtered SCL is low;
- every write strobe and every pointer change coincides with an acknowledge being driven;
- SDA is released one cycle after a stop;
- the engine drives nothing while it is ignoring a transaction.

Other behaviour can only be shown by the bench's scenarios, which compare bytes against a behavioural model of the bus and the register bank. These cover:
- address decoding against changing straps;
- that the pointer neither increments nor is lost across a restart;
- silence after a mismatch or after a stop;
- data integrity when single-cycle glitches form false edges, starts and stops.

// File: rtl/i2cx_pkg.sv
package i2cx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_SKIP
  } link_st_t;

  typedef enum logic [1:0] {
    BK_ADDR,
    BK_CMD,
    BK_DATA
  } byte_kind_t;

endpackage

// File: rtl/i2cx_line_filter.sv
module i2cx_line_filter #(
  parameter int   TAPS = 3,
  parameter logic IDLE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic clean
);

  logic [1:0]      sync_q;
  logic [TAPS-1:0] hist_q;
  logic            clean_q;

  // Majority vote over the history window.
  function automatic logic vote(input logic [TAPS-1:0] v);
    int n;
    n = 0;
    for (int i = 0; i < TAPS; i++) n += int'(v[i]);
    return n > TAPS / 2;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= {2{IDLE}};
      hist_q  <= {TAPS{IDLE}};
      clean_q <= IDLE;
    end else begin
      sync_q  <= {sync_q[0], raw};
      hist_q  <= {hist_q[TAPS-2:0], sync_q[1]};
      clean_q <= vote(hist_q);
    end
  end

  assign clean = clean_q;

endmodule

// File: rtl/i2cx_bus_events.sv
module i2cx_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);

  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  assign scl_rise  = scl & ~scl_q;
  assign scl_fall  = ~scl & scl_q;
  assign bus_start = scl & scl_q & sda_q & ~sda;
  assign bus_stop  = scl & scl_q & ~sda_q & sda;

endmodule

// File: rtl/i2cx_link_fsm.sv
module i2cx_link_fsm
  import i2cx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int STRAP_W = 3,
  parameter int PTR_W   = 2,
  parameter logic [DATA_W-STRAP_W-2:0] ADDR_HI = 4'b0011
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STRAP_W-1:0] strap,
  input  logic               sda_in,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               bus_start,
  input  logic               bus_stop,
  input  logic [DATA_W-1:0]  rd_data,
  output logic               sda_oe,
  output logic [PTR_W-1:0]   ptr,
  output logic [DATA_W-1:0]  wr_data,
  output logic               wr_stb,
  output logic               rd_req
);

  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DATA_W - 1);

  link_st_t          state;
  byte_kind_t        kind;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] shf;
  logic              full, go_tx, more;
  logic              sda_oe_q, wstb_q, rreq_q;
  logic [PTR_W-1:0]  ptr_q;
  logic [DATA_W-1:0] wdat_q;

  // Address comparison: fixed high part concatenated with the straps.
  function automatic logic addr_hit(input logic [DATA_W-2:0] rx,
                                    input logic [STRAP_W-1:0] s);
    return rx == {ADDR_HI, s};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      kind     <= BK_ADDR;
      cnt      <= '0;
      shf      <= '0;
      full     <= 1'b0;
      go_tx    <= 1'b0;
      more     <= 1'b0;
      sda_oe_q <= 1'b0;
      ptr_q    <= '0;
      wdat_q   <= '0;
      wstb_q   <= 1'b0;
      rreq_q   <= 1'b0;
    end else begin
      wstb_q <= 1'b0;
      rreq_q <= 1'b0;
      if (bus_start) begin
        state    <= ST_RX;
        kind     <= BK_ADDR;
        cnt      <= '0;
        full     <= 1'b0;
        sda_oe_q <= 1'b0;
      end else if (bus_stop) begin
        state    <= ST_IDLE;
        full     <= 1'b0;
        sda_oe_q <= 1'b0;
      end else begin
        case (state)
          ST_RX: begin
            if (scl_rise && !full) begin
              shf <= {shf[DATA_W-2:0], sda_in};
              if (cnt == CNT_MAX) full <= 1'b1;
              else                cnt  <= cnt + 1'b1;
            end else if (scl_fall && full) begin
              full <= 1'b0;
              cnt  <= '0;
              case (kind)
                BK_ADDR: begin
                  if (addr_hit(shf[DATA_W-1:1], strap)) begin
                    sda_oe_q <= 1'b1;
                    go_tx    <= shf[0];
                    kind     <= BK_CMD;
                    state    <= ST_ACK;
                  end else begin
                    state <= ST_SKIP;
                  end
                end
                BK_CMD: begin
                  ptr_q    <= shf[PTR_W-1:0];
                  sda_oe_q <= 1'b1;
                  go_tx    <= 1'b0;
                  kind     <= BK_DATA;
                  state    <= ST_ACK;
                end
                default: begin
                  wdat_q   <= shf;
                  wstb_q   <= 1'b1;
                  sda_oe_q <= 1'b1;
                  go_tx    <= 1'b0;
                  state    <= ST_ACK;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              if (go_tx) begin
                shf      <= rd_data;
                rreq_q   <= 1'b1;
                sda_oe_q <= ~rd_data[DATA_W-1];
                cnt      <= '0;
                state    <= ST_TX;
              end else begin
                sda_oe_q <= 1'b0;
                state    <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (cnt == CNT_MAX) begin
                sda_oe_q <= 1'b0;
                state    <= ST_MACK;
              end else begin
                cnt      <= cnt + 1'b1;
                shf      <= shf << 1;
                sda_oe_q <= ~shf[DATA_W-2];
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              more <= ~sda_in;
            end else if (scl_fall) begin
              if (more) begin
                shf      <= rd_data;
                rreq_q   <= 1'b1;
                sda_oe_q <= ~rd_data[DATA_W-1];
                cnt      <= '0;
                state    <= ST_TX;
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe  = sda_oe_q;
  assign ptr     = ptr_q;
  assign wr_data = wdat_q;
  assign wr_stb  = wstb_q;
  assign rd_req  = rreq_q;

  // R4: a write strobe is always accompanied by an acknowledge.
  p_wr_acked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wstb_q |-> sda_oe_q);

  // R5: the pointer changes only while the command byte is acknowledged.
  p_ptr_acked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ptr_q) |-> sda_oe_q);

  // R11: a stop releases SDA.
  p_stop_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stop |=> !sda_oe_q);

  // R2: nothing is driven while a transaction is ignored.
  p_skip_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SKIP) |-> (!sda_oe_q && !wstb_q && !rreq_q));

endmodule

// File: rtl/i2c_regacc_engine.sv
module i2c_regacc_engine #(
  parameter int DATA_W    = 8,
  parameter int STRAP_W   = 3,
  parameter int PTR_W     = 2,
  parameter int FILT_TAPS = 3,
  parameter logic [DATA_W-STRAP_W-2:0] ADDR_HI = 4'b0011
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic [DATA_W-1:0]  rd_data_i,
  output logic               sda_pull_o,
  output logic [PTR_W-1:0]   reg_sel_o,
  output logic [DATA_W-1:0]  wr_data_o,
  output logic               wr_stb_o,
  output logic               rd_req_o
);

  localparam int N_LINES = 2;

  logic [N_LINES-1:0] line_raw, line_clean;
  logic scl_f, sda_f;
  logic ev_rise, ev_fall, ev_start, ev_stop;

  assign line_raw = {sda_i, scl_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_filt
    i2cx_line_filter #(.TAPS(FILT_TAPS), .IDLE(1'b1)) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .raw   (line_raw[g]),
      .clean (line_clean[g])
    );
  end

  assign scl_f = line_clean[0];
  assign sda_f = line_clean[1];

  i2cx_bus_events u_events (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl       (scl_f),
    .sda       (sda_f),
    .scl_rise  (ev_rise),
    .scl_fall  (ev_fall),
    .bus_start (ev_start),
    .bus_stop  (ev_stop)
  );

  i2cx_link_fsm #(
    .DATA_W  (DATA_W),
    .STRAP_W (STRAP_W),
    .PTR_W   (PTR_W),
    .ADDR_HI (ADDR_HI)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .strap     (strap_i),
    .sda_in    (sda_f),
    .scl_rise  (ev_rise),
    .scl_fall  (ev_fall),
    .bus_start (ev_start),
    .bus_stop  (ev_stop),
    .rd_data   (rd_data_i),
    .sda_oe    (sda_pull_o),
    .ptr       (reg_sel_o),
    .wr_data   (wr_data_o),
    .wr_stb    (wr_stb_o),
    .rd_req    (rd_req_o)
  );

  // R3: the SDA drive changes only while the cleaned SCL is low.
  p_sda_chg_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_o) |-> !scl_f);

  // R1: a start always restarts with SDA released.
  p_start_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> !sda_pull_o);

endmodule

// File: tb/tb_i2c_regacc_engine.sv
`timescale 1ns/1ps
module tb_i2c_regacc_engine;

  localparam int HP = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_r = 1'b1;
  logic       m_sda = 1'b1;
  logic [2:0] strap = 3'b101;
  logic [7:0] rd_data;
  logic       sda_oe, wr_stb, rd_req;
  logic [1:0] reg_sel;
  logic [7:0] wr_data;
  logic       sda_line;

  int checks = 0, errors = 0;
  int rd_cnt = 0, oe_viol = 0, stray_wr = 0;
  bit wr_ok = 0, done = 0;
  logic prev_oe = 1'b0;
  logic [9:0] wr_q[$];

  always #2.5 clk = ~clk;

  // Behavioural register bank seen by the engine.
  function automatic logic [7:0] bank(input logic [1:0] p);
    case (p)
      2'd0: return 8'h5A;
      2'd1: return 8'hC3;
      2'd2: return 8'h3F;
      default: return 8'h81;
    endcase
  endfunction

  assign rd_data  = bank(reg_sel);
  assign sda_line = m_sda & ~sda_oe;

  i2c_regacc_engine dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_r),
    .sda_i      (sda_line),
    .strap_i    (strap),
    .rd_data_i  (rd_data),
    .sda_pull_o (sda_oe),
    .reg_sel_o  (reg_sel),
    .wr_data_o  (wr_data),
    .wr_stb_o   (wr_stb),
    .rd_req_o   (rd_req)
  );

  // Per-clock monitor against the model of legal behaviour.
  always @(negedge clk) begin
    if (rst_n) begin
      if (sda_oe !== prev_oe && scl_r) oe_viol++;
      if (wr_stb) begin
        if (!wr_ok) stray_wr++;
        wr_q.push_back({reg_sel, wr_data});
      end
      if (rd_req) rd_cnt++;
    end
    prev_oe = sda_oe;
  end

  task automatic chk(input logic ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic bus_start();
    m_sda <= 1'b1; tick(HP/2);
    scl_r <= 1'b1; tick(HP);
    m_sda <= 1'b0; tick(HP);
    scl_r <= 1'b0; tick(HP/2);
  endtask

  task automatic bus_stop();
    m_sda <= 1'b0; tick(HP/2);
    scl_r <= 1'b1; tick(HP);
    m_sda <= 1'b1; tick(HP);
  endtask

  // One bit with SCL low on entry; glitch 1 = SCL dip, 2 = SDA flip.
  task automatic xfer_bit(input logic b, input int glitch, output logic seen);
    tick(4);      m_sda <= b;
    tick(HP - 4); scl_r <= 1'b1;
    tick(HP/2 - 2);
    if (glitch == 1)      begin scl_r <= 1'b0; tick(1); scl_r <= 1'b1; end
    else if (glitch == 2) begin m_sda <= ~b;   tick(1); m_sda <= b;    end
    else tick(1);
    tick(1);
    @(negedge clk); seen = sda_line;
    tick(HP/2 - 1);
    scl_r <= 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v, input int gbit, input int gkind,
                           output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) xfer_bit(v[i], (i == gbit) ? gkind : 0, s);
    xfer_bit(1'b1, 0, s);
    acked = !s;
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin xfer_bit(1'b1, 0, s); v[i] = s; end
    xfer_bit(nack, 0, s);
  endtask

  initial begin
    logic a;
    logic [7:0] v1, v2;
    int rc;
    tick(6); rst_n <= 1'b1; tick(10);
    @(negedge clk);
    chk(reg_sel == 2'd0, "R9 reset pointer", reg_sel, 0);
    chk(sda_oe == 1'b0,  "R9 reset SDA released", sda_oe, 0);
    chk(wr_stb == 1'b0,  "R9 reset no strobe", wr_stb, 0);

    // Read with no command byte: default register 00.
    bus_start(); send_byte({7'h1D, 1'b1}, -1, 0, a);
    chk(a, "R1 read address ack", a, 1);
    recv_byte(1'b1, v1);
    chk(v1 == bank(2'd0), "R9 default read returns register 00", v1, bank(2'd0));
    chk(rd_cnt == 1, "R8 one read request per byte", rd_cnt, 1);
    tick(6); @(negedge clk);
    chk(sda_oe == 1'b0, "R8 SDA released after NACK", sda_oe, 0);
    bus_stop();

    // Write: command with junk upper bits, then three data bytes.
    wr_ok = 1; wr_q.delete();
    bus_start(); send_byte(8'h3A, -1, 0, a);
    chk(a, "R1 write address ack", a, 1);
    send_byte(8'hFD, -1, 0, a);
    chk(a, "R5 command ack", a, 1);
    send_byte(8'h11, -1, 0, a); chk(a, "R4 data ack", a, 1);
    send_byte(8'h22, -1, 0, a); chk(a, "R4 data ack", a, 1);
    send_byte(8'h33, -1, 0, a); chk(a, "R4 data ack", a, 1);
    bus_stop(); wr_ok = 0;
    chk(reg_sel == 2'd1, "R5 pointer from low command bits", reg_sel, 1);
    chk(wr_q.size() == 3, "R4 one strobe per byte", wr_q.size(), 3);
    if (wr_q.size() == 3) begin
      chk(wr_q[0] == {2'd1, 8'h11}, "R6 byte 0 same pointer", wr_q[0], {2'd1, 8'h11});
      chk(wr_q[1] == {2'd1, 8'h22}, "R6 byte 1 same pointer", wr_q[1], {2'd1, 8'h22});
      chk(wr_q[2] == {2'd1, 8'h33}, "R6 byte 2 same pointer", wr_q[2], {2'd1, 8'h33});
    end

    // Command, repeated start, two-byte read.
    wr_q.delete(); rc = rd_cnt;
    bus_start(); send_byte(8'h3A, -1, 0, a); send_byte(8'h02, -1, 0, a);
    bus_start(); send_byte(8'h3B, -1, 0, a);
    chk(a, "R7 read address after restart ack", a, 1);
    recv_byte(1'b0, v1); recv_byte(1'b1, v2);
    bus_stop();
    chk(v1 == bank(2'd2), "R7 first read byte", v1, bank(2'd2));
    chk(v2 == bank(2'd2), "R7 second read byte no increment", v2, bank(2'd2));
    chk(rd_cnt == rc + 2, "R8 read requests", rd_cnt, rc + 2);
    chk(reg_sel == 2'd2, "R7 pointer kept", reg_sel, 2);

    // Address mismatch: write then read.
    rc = rd_cnt;
    bus_start(); send_byte(8'h38, -1, 0, a);
    chk(!a, "R2 mismatched address not acked", a, 0);
    send_byte(8'h03, -1, 0, a);
    chk(!a, "R2 following byte not acked", a, 0);
    send_byte(8'h55, -1, 0, a);
    bus_stop();
    chk(wr_q.size() == 0, "R2 no write strobe", wr_q.size(), 0);
    chk(reg_sel == 2'd2, "R2 pointer unchanged", reg_sel, 2);
    bus_start(); send_byte(8'h39, -1, 0, a); recv_byte(1'b1, v1); bus_stop();
    chk(v1 == 8'hFF, "R2 mismatched read sees idle bus", v1, 8'hFF);
    chk(rd_cnt == rc, "R2 no read request", rd_cnt, rc);

    // Bytes clocked after a stop with no start.
    scl_r <= 1'b0; tick(HP);
    send_byte(8'h3A, -1, 0, a);
    chk(!a, "R11 no ack without start", a, 0);
    send_byte(8'h01, -1, 0, a);
    bus_stop();
    chk(reg_sel == 2'd2, "R11 pointer unchanged after stop", reg_sel, 2);

    // Single-cycle glitches: SCL dip, false start, false stop.
    wr_ok = 1; wr_q.delete();
    bus_start(); send_byte(8'h3A, -1, 0, a); send_byte(8'h01, -1, 0, a);
    send_byte(8'hA5, 4, 1, a); chk(a, "R10 ack with SCL glitch", a, 1);
    send_byte(8'h5A, 6, 2, a); chk(a, "R10 ack with false start", a, 1);
    send_byte(8'h96, 5, 2, a); chk(a, "R10 ack with false stop", a, 1);
    bus_stop(); wr_ok = 0;
    chk(wr_q.size() == 3, "R10 strobes under glitches", wr_q.size(), 3);
    if (wr_q.size() == 3) begin
      chk(wr_q[0] == {2'd1, 8'hA5}, "R10 byte after SCL glitch", wr_q[0], {2'd1, 8'hA5});
      chk(wr_q[1] == {2'd1, 8'h5A}, "R10 byte after false start", wr_q[1], {2'd1, 8'h5A});
      chk(wr_q[2] == {2'd1, 8'h96}, "R10 byte after false stop", wr_q[2], {2'd1, 8'h96});
    end

    // Other strap value: address 0x18.
    strap = 3'b000; tick(4);
    bus_start(); send_byte(8'h30, -1, 0, a);
    chk(a, "R1 ack at strap 000", a, 1);
    send_byte(8'h03, -1, 0, a);
    bus_stop();
    chk(reg_sel == 2'd3, "R5 pointer 11", reg_sel, 3);

    // Reset in the middle of a transaction.
    bus_start(); send_byte(8'h30, -1, 0, a); send_byte(8'h02, -1, 0, a);
    tick(4);
    rst_n <= 1'b0; scl_r <= 1'b1; m_sda <= 1'b1; tick(4);
    @(negedge clk);
    chk(reg_sel == 2'd0, "R9 reset clears pointer", reg_sel, 0);
    chk(sda_oe == 1'b0, "R9 reset releases SDA", sda_oe, 0);
    rst_n <= 1'b1; tick(10);
    bus_start(); send_byte(8'h31, -1, 0, a); recv_byte(1'b1, v1); bus_stop();
    chk(v1 == bank(2'd0), "R9 read after reset returns register 00", v1, bank(2'd0));

    chk(oe_viol == 0, "R3 SDA drive changed while SCL high", oe_viol, 0);
    chk(stray_wr == 0, "R2 stray write strobes", stray_wr, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule